// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank/Burst Tracker

This block sits on the memory side of a single-data-rate SDRAM interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines, together with clock-enable, the address bus, the bank-select bits and the data mask. From these it works out which command was issued. It keeps a mode register, holds a flag for each of four banks that says whether a row is open, and follows one read or write burst at a time. A refresh counter steps on each refresh, and a self-refresh flag shows the low-power state.

The block has two data-side outputs. One is a per-cycle read drive enable. It appears a programmable latency after the read command, and the mask pin acts on it two cycles late. The other is a write strobe. It is combinational with the inputs, so the mask acts on it in the same cycle. A mode bit can make every write a single-location access while reads keep the programmed length. Commands that break the protocol raise a one-cycle error flag and otherwise have no effect.

The burst follower is a three-state machine with the states IDLE, READ and WRITE. The transitions are: IDLE to READ on a legal read, and IDLE to WRITE on a legal write whose write length is above one. READ or WRITE return to IDLE when the last beat is counted, or on burst terminate. A new legal read moves any state to READ. A new legal write moves any state to WRITE, or to IDLE when the write length is one.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While cs_n is high the edge carries no command. The mode register, the bank flags and the refresh counter keep their values, no burst starts, and err stays low. Any burst already running keeps counting.
- R2: The command is taken from {ras_n,cas_n,we_n}: 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 110 BURST TERMINATE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE. A load with addr[12] low copies addr[11:0] into mode_q, and the new value shows from the next cycle.
- R3: A legal ACTIVE sets bank_open[ba] after the edge.
- R4: On PRECHARGE with addr[10] low only bank_open[ba] clears. With addr[10] high all four flags clear and ba is ignored.
- R5: The burst length comes from mode_q[2:0]: 000 gives 1, 001 gives 2, 010 gives 4, and any other code gives 8. A legal read with no interruption drives dq_oe for exactly that many consecutive cycles.
- R6: The CAS latency is 2 when mode_q[6:4] is 010 and 3 for any other code. For a READ sampled at edge k, dq_oe is high in the cycles that end at edges k+CL through k+CL+BL-1.
- R7: dqm sampled high at edge m forces dq_oe low in the cycle that ends at edge m+2.
- R8: wr_strobe is high, in the same cycle, at the edge of a legal WRITE and at each later beat of the write burst, but only while dqm is low in that same cycle.
- R9: With mode_q[9] at 0, writes use the burst length of R5. With mode_q[9] at 1, each write is one beat long and reads keep the burst length of R5.
- R10: BURST TERMINATE ends the current burst at its edge, and that edge carries no write beat. A new legal READ or WRITE cuts off the running burst and starts its own.
- R11: With addr[10] high on a READ or WRITE, the bank is closed at the edge of the burst's last counted beat. For a READ sampled at edge k this is edge k+BL. For a WRITE it is edge k+WBL-1. A burst cut short by terminate or by a new access leaves the bank open.
- R12: err is high for one cycle after any of these: a READ or WRITE to a closed bank, an ACTIVE to an open bank, a REFRESH while any bank is open, or a LOAD MODE with addr[12] high. Such a command changes no other state.
- R13: A legal REFRESH increments ref_row. If cke is low at that edge, self_ref also goes high. It stays high until the first edge with cke high, and every command is ignored while it is high, including the command at the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; selects self refresh and exits it |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Row, column, op-code and precharge-all bit |
| ba | input | 2 | Bank select |
| dqm | input | 1 | Data mask |
| dq_oe | output | 1 | Read data drive enable |
| wr_strobe | output | 1 | Write beat accepted in this cycle |
| bank_open | output | 4 | One flag per bank, high while a row is open |
| mode_q | output | 12 | Mode register contents |
| ref_row | output | 13 | Internal refresh row counter |
| self_ref | output | 1 | Self refresh active |
| err | output | 1 | Protocol error seen at the previous edge |

## Verification
The bench goes after the places where the two mask latencies differ. A design that delayed the write mask would strobe a masked beat. A design that applied the read mask at once would blank the wrong read cycle. The bench also checks auto-precharge at a burst's natural end against a burst that is terminated or cut off; a design that closes the bank in both cases would show a missing bank flag. It switches the write length between burst and single-location while reads stay long, and it issues commands with chip select high whose other lines would look like a mode load. It enters and leaves self refresh with commands on the lines. Illegal commands must leave banks, mode and counter untouched, so a design that half-executes one is caught by the next comparison.

// File: rtl/sdram_trk_pkg.sv
`timescale 1ns/1ps
package sdram_trk_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [3:0] {
        CMD_INH, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_BST, CMD_PRE, CMD_REF, CMD_LMR
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE, BS_READ, BS_WRITE
    } bst_e;

    function automatic logic [LEN_W-1:0] burst_len(input logic [2:0] code);
        logic [LEN_W-1:0] len;
        case (code)
            3'b000:  len = LEN_W'(1);
            3'b001:  len = LEN_W'(2);
            3'b010:  len = LEN_W'(4);
            default: len = LEN_W'(8);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_INH;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
module sdram_bank_track #(
    parameter int NB   = 4,
    parameter int BA_W = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_set,
    input  logic            pre_one,
    input  logic            pre_all,
    input  logic [BA_W-1:0] ba,
    input  logic [NB-1:0]   close_mask,
    output logic [NB-1:0]   open_q
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic q;
        wire  sel = (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (close_mask[b] || pre_all || (pre_one && sel))
                q <= 1'b0;
            else if (act_set && sel)
                q <= 1'b1;
        end

        assign open_q[b] = q;
    end

endmodule

// File: rtl/sdram_burst_fsm.sv
`timescale 1ns/1ps
module sdram_burst_fsm
    import sdram_trk_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic             stop,
    input  logic [BA_W-1:0]  ba,
    input  logic             auto_pre,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             cl3,
    input  logic             dqm,
    output logic             dq_oe,
    output logic             wr_strobe,
    output logic [NB-1:0]    close_mask
);

    bst_e             st, st_n;
    logic [LEN_W-1:0] cnt, cnt_n;
    logic             ap_q, ap_n;
    logic [BA_W-1:0]  bank_q, bank_n;
    logic [1:0]       rd_pipe;
    logic [1:0]       dqm_d;
    logic             last_beat;

    assign last_beat = (st != BS_IDLE) && (cnt == LEN_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BS_IDLE;
            cnt     <= '0;
            ap_q    <= 1'b0;
            bank_q  <= '0;
            rd_pipe <= '0;
            dqm_d   <= '0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            ap_q    <= ap_n;
            bank_q  <= bank_n;
            rd_pipe <= {rd_pipe[0], st == BS_READ};
            dqm_d   <= {dqm_d[0], dqm};
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        ap_n   = ap_q;
        bank_n = bank_q;
        unique case (st)
            BS_IDLE: ;
            BS_READ, BS_WRITE: begin
                if (last_beat) st_n = BS_IDLE;
                else           cnt_n = cnt - LEN_W'(1);
            end
            default: st_n = BS_IDLE;
        endcase
        if (stop) st_n = BS_IDLE;
        if (start_rd) begin
            st_n   = BS_READ;
            cnt_n  = rd_len;
            ap_n   = auto_pre;
            bank_n = ba;
        end else if (start_wr) begin
            st_n   = (wr_len > LEN_W'(1)) ? BS_WRITE : BS_IDLE;
            cnt_n  = wr_len - LEN_W'(1);
            ap_n   = auto_pre;
            bank_n = ba;
        end
    end

    // outputs
    always_comb begin
        close_mask = '0;
        if (last_beat && !stop && ap_q)
            close_mask[bank_q] = 1'b1;
        if (start_wr && (wr_len == LEN_W'(1)) && auto_pre)
            close_mask[ba] = 1'b1;
        dq_oe     = (cl3 ? rd_pipe[1] : rd_pipe[0]) & ~dqm_d[1];
        wr_strobe = (start_wr | ((st == BS_WRITE) & ~stop & ~start_rd)) & ~dqm;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int NB     = 4,
    parameter int MODE_W = 12,
    parameter int BA_W   = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [BA_W-1:0]   ba,
    input  logic              dqm,
    output logic              dq_oe,
    output logic              wr_strobe,
    output logic [NB-1:0]     bank_open,
    output logic [MODE_W-1:0] mode_q,
    output logic [ROW_W-1:0]  ref_row,
    output logic              self_ref,
    output logic              err
);

    localparam int AP_BIT = 10;

    cmd_e             cmd_raw, cmd;
    logic             hit, any_open;
    logic             rd_ok, wr_ok, act_ok, ref_ok, lmr_ok, bad;
    logic [LEN_W-1:0] rd_len, wr_len;
    logic             cl3;
    logic [NB-1:0]    close_mask;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd_raw)
    );

    assign cmd      = self_ref ? CMD_INH : cmd_raw;
    assign hit      = bank_open[ba];
    assign any_open = |bank_open;
    assign rd_ok    = (cmd == CMD_RD)  &&  hit;
    assign wr_ok    = (cmd == CMD_WR)  &&  hit;
    assign act_ok   = (cmd == CMD_ACT) && !hit;
    assign ref_ok   = (cmd == CMD_REF) && !any_open;
    assign lmr_ok   = (cmd == CMD_LMR) && !addr[ROW_W-1];
    assign bad      = ((cmd == CMD_RD || cmd == CMD_WR) && !hit)
                    || ((cmd == CMD_ACT) && hit)
                    || ((cmd == CMD_REF) && any_open)
                    || ((cmd == CMD_LMR) && addr[ROW_W-1]);

    assign rd_len = burst_len(mode_q[2:0]);
    assign wr_len = mode_q[9] ? LEN_W'(1) : rd_len;
    assign cl3    = (mode_q[6:4] != 3'b010);

    sdram_bank_track #(.NB(NB), .BA_W(BA_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_set   (act_ok),
        .pre_one   ((cmd == CMD_PRE) && !addr[AP_BIT]),
        .pre_all   ((cmd == CMD_PRE) &&  addr[AP_BIT]),
        .ba        (ba),
        .close_mask(close_mask),
        .open_q    (bank_open)
    );

    sdram_burst_fsm #(.NB(NB), .BA_W(BA_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (rd_ok),
        .start_wr  (wr_ok),
        .stop      (cmd == CMD_BST),
        .ba        (ba),
        .auto_pre  (addr[AP_BIT]),
        .rd_len    (rd_len),
        .wr_len    (wr_len),
        .cl3       (cl3),
        .dqm       (dqm),
        .dq_oe     (dq_oe),
        .wr_strobe (wr_strobe),
        .close_mask(close_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ref_row  <= '0;
            self_ref <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= bad;
            if (lmr_ok) mode_q  <= addr[MODE_W-1:0];
            if (ref_ok) ref_row <= ref_row + ROW_W'(1);
            if (self_ref && cke)      self_ref <= 1'b0;
            else if (ref_ok && !cke)  self_ref <= 1'b1;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_chk #(
    parameter int ROW_W  = 13,
    parameter int NB     = 4,
    parameter int MODE_W = 12,
    parameter int BA_W   = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ROW_W-1:0]  addr,
    input logic [BA_W-1:0]   ba,
    input logic              dqm,
    input logic              wr_strobe,
    input logic [NB-1:0]     bank_open,
    input logic [MODE_W-1:0] mode_q,
    input logic [ROW_W-1:0]  ref_row,
    input logic              self_ref,
    input logic              err
);

    wire live = !cs_n && !self_ref;
    wire [2:0] op = {ras_n, cas_n, we_n};

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(mode_q) && $stable(ref_row) && !err)); // R1
    AST_LMR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == 3'b000 && !addr[ROW_W-1]) |=> (mode_q == $past(addr[MODE_W-1:0]))); // R2
    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == 3'b010 && addr[10]) |=> (bank_open == '0)); // R4
    AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !dqm); // R8
    AST_ACT_OPEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == 3'b011 && bank_open[ba]) |=> err); // R12
    AST_RD_CLOSED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == 3'b101 && !bank_open[ba]) |=> err); // R12
    AST_REF_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == 3'b001 && bank_open == '0) |=> (ref_row == $past(ref_row) + 1'b1)); // R13
    AST_SREF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref && !cke) |=> self_ref); // R13

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .ROW_W(ROW_W), .NB(NB), .MODE_W(MODE_W), .BA_W(BA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .ba       (ba),
    .dqm      (dqm),
    .wr_strobe(wr_strobe),
    .bank_open(bank_open),
    .mode_q   (mode_q),
    .ref_row  (ref_row),
    .self_ref (self_ref),
    .err      (err)
);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;

    localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD  = 4'b0101,
                           K_WR  = 4'b0100, K_BST = 4'b0110, K_PRE = 4'b0010,
                           K_REF = 4'b0001, K_LMR = 4'b0000, K_INH = 4'b1000;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic        dqm = 1'b0;
    logic dq_oe, wr_strobe, self_ref, err;
    logic [3:0]  bank_open;
    logic [11:0] mode_q;
    logic [12:0] ref_row;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm),
        .dq_oe(dq_oe), .wr_strobe(wr_strobe), .bank_open(bank_open),
        .mode_q(mode_q), .ref_row(ref_row), .self_ref(self_ref), .err(err)
    );

    int checks = 0, errors = 0, n = 0;
    logic [3:0]  m_open = '0;
    logic [11:0] m_mode = '0;
    logic [12:0] m_ref = '0;
    bit m_sref = 0, m_err = 0, m_ap = 0;
    int m_st = 0, m_cnt = 0, m_bank = 0;
    bit rdb [0:4095];
    bit dqh [0:4095];

    function automatic int blen(input logic [11:0] m);
        case (m[2:0])
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit past_rd(input int i);
        return (i < 0) ? 1'b0 : rdb[i];
    endfunction

    function automatic bit past_dqm(input int i);
        return (i < 0) ? 1'b0 : dqh[i];
    endfunction

    task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, n);
        end
    endtask

    task automatic cyc(input logic [3:0] k, input logic [12:0] a, input logic [1:0] b,
                       input logic dq, input logic ck);
        bit inh, rdok, wrok, actok, refok, lmrok, bst, bad;
        int op, cl, wbl;
        logic [3:0] nopen;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = k;
        addr = a; ba = b; dqm = dq; cke = ck;
        #1;
        inh   = m_sref || cs_n;
        op    = {ras_n, cas_n, we_n};
        rdok  = !inh && op == 5 &&  m_open[b];
        wrok  = !inh && op == 4 &&  m_open[b];
        actok = !inh && op == 3 && !m_open[b];
        refok = !inh && op == 1 && m_open == 0;
        lmrok = !inh && op == 0 && !a[12];
        bst   = !inh && op == 6;
        bad   = !inh && (((op == 5 || op == 4) && !m_open[b]) || (op == 3 && m_open[b])
                      || (op == 1 && m_open != 0) || (op == 0 && a[12]));
        cl    = (m_mode[6:4] == 3'b010) ? 2 : 3;
        wbl   = m_mode[9] ? 1 : blen(m_mode);
        // registered outputs reflect edge n-1; wr_strobe reflects the present inputs
        cmp("R5/R6/R7/R10 dq_oe", 16'(dq_oe),
            16'(past_rd(n - 1 - (cl - 1)) && !past_dqm(n - 2)));
        cmp("R8/R9/R10 wr_strobe", 16'(wr_strobe),
            16'((wrok || (m_st == 2 && !bst && !rdok)) && !dq));
        cmp("R1/R3/R4/R11 bank_open", 16'(bank_open), 16'(m_open));
        cmp("R1/R2 mode_q", 16'(mode_q), 16'(m_mode));
        cmp("R13 ref_row", 16'(ref_row), 16'(m_ref));
        cmp("R13 self_ref", 16'(self_ref), 16'(m_sref));
        cmp("R12 err", 16'(err), 16'(m_err));
        @(posedge clk);
        nopen = m_open;
        if (m_st != 0 && m_cnt == 1 && !bst && m_ap) nopen[m_bank] = 1'b0;
        if (!inh && op == 2) begin
            if (a[10]) nopen = '0;
            else       nopen[b] = 1'b0;
        end
        if (actok) nopen[b] = 1'b1;
        if (wrok && wbl == 1 && a[10]) nopen[b] = 1'b0;
        if (m_st != 0) begin
            if (m_cnt == 1) m_st = 0;
            else            m_cnt--;
        end
        if (bst) m_st = 0;
        if (rdok) begin
            m_st = 1; m_cnt = blen(m_mode); m_ap = a[10]; m_bank = b;
        end else if (wrok) begin
            m_st = (wbl > 1) ? 2 : 0; m_cnt = wbl - 1; m_ap = a[10]; m_bank = b;
        end
        if (lmrok) m_mode = a[11:0];
        if (refok) m_ref = m_ref + 13'd1;
        if (m_sref && ck)        m_sref = 0;
        else if (refok && !ck)   m_sref = 1;
        m_err  = bad;
        m_open = nopen;
        if (n < 4096) begin
            dqh[n] = dq;
            rdb[n] = (m_st == 1);
        end
        n++;
    endtask

    task automatic c(input logic [3:0] k, input logic [12:0] a, input logic [1:0] b);
        cyc(k, a, b, 1'b0, 1'b1);
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) c(K_NOP, 13'h0, 2'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired at edge %0d", n);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin rdb[i] = 0; dqh[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R12 err low and all banks closed
        cmp("R12 reset err", 16'(err), 16'h0);
        cmp("R3 reset bank_open", 16'(bank_open), 16'h0);
        cmp("R6 reset dq_oe", 16'(dq_oe), 16'h0);
        rst_n = 1'b1;
        idle(2);
        // R2: BL4, CL2, M9=0
        c(K_LMR, 13'h022, 2'd0);  idle(1);
        c(K_ACT, 13'h005, 2'd0);  c(K_ACT, 13'h009, 2'd1);
        // R5/R6/R7 read BL4 CL2 with mask pulses
        c(K_RD, 13'h000, 2'd0);
        cyc(K_NOP, 0, 0, 1'b1, 1'b1); c(K_NOP, 0, 0); cyc(K_NOP, 0, 0, 1'b1, 1'b1);
        idle(5);
        // R8 write BL4 with mask in beat 1
        c(K_WR, 13'h010, 2'd1);
        cyc(K_NOP, 0, 0, 1'b1, 1'b1); idle(4);
        // R1: chip select high, lines look like a mode load
        cyc(K_INH, 13'h0fff, 2'd2, 1'b0, 1'b1); idle(1);
        // R12 illegal commands
        c(K_ACT, 13'h001, 2'd0); c(K_RD, 13'h0, 2'd2); c(K_WR, 13'h0, 2'd3);
        c(K_LMR, 13'h1033, 2'd0); c(K_REF, 13'h0, 2'd0); idle(1);
        // R11 read with auto-precharge
        c(K_RD, 13'h400, 2'd0); idle(7);
        // R9: M9=1, CL3, BL8
        c(K_LMR, 13'h233, 2'd0); idle(1);
        c(K_WR, 13'h000, 2'd1); idle(2);
        c(K_WR, 13'h400, 2'd1); idle(2);
        // R10 terminate a CL3 BL8 read
        c(K_ACT, 13'h0, 2'd2); c(K_RD, 13'h0, 2'd2); idle(3);
        c(K_BST, 13'h0, 2'd0); idle(6);
        // R9/R10 write cuts a read
        c(K_RD, 13'h0, 2'd2); c(K_NOP, 0, 0); c(K_WR, 13'h0, 2'd2); idle(6);
        // BL8 CL2, M9=0; write cut by read, auto-precharge cancelled (R11)
        c(K_LMR, 13'h023, 2'd0); idle(1);
        c(K_ACT, 13'h0, 2'd3); c(K_WR, 13'h400, 2'd3); idle(2);
        c(K_RD, 13'h400, 2'd3); idle(2); c(K_RD, 13'h000, 2'd2); idle(12);
        // R4 precharge one, then all
        c(K_PRE, 13'h000, 2'd2); idle(1); c(K_PRE, 13'h400, 2'd1); idle(1);
        // R13 refresh, self refresh with ignored commands
        c(K_REF, 0, 0); c(K_REF, 0, 0);
        cyc(K_REF, 0, 0, 1'b0, 1'b0);
        cyc(K_ACT, 0, 0, 1'b0, 1'b0); cyc(K_REF, 0, 0, 1'b0, 1'b0);
        cyc(K_ACT, 0, 1, 1'b0, 1'b1);
        idle(1); c(K_ACT, 13'h0, 2'd0);
        // CL code 001 counts as 3 (R6), BL4 with masks
        c(K_LMR, 13'h012, 2'd0); idle(1);
        c(K_RD, 13'h0, 2'd0); cyc(K_NOP, 0, 0, 1'b1, 1'b1); idle(1);
        cyc(K_NOP, 0, 0, 1'b1, 1'b1); idle(6);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] k;
            int r;
            r = int'($urandom_range(0, 19));
            case (r)
                0, 1, 2:    k = K_ACT;
                3, 4, 5:    k = K_RD;
                6, 7, 8:    k = K_WR;
                9:          k = K_BST;
                10, 11:     k = K_PRE;
                12:         k = K_REF;
                13:         k = K_LMR;
                14:         k = K_INH;
                default:    k = K_NOP;
            endcase
            cyc(k, {1'($urandom_range(0, 9) == 0), 2'b00,
                    1'($urandom_range(0, 3) == 0), 2'b00, 3'($urandom), 1'b0,
                    3'($urandom)},
                2'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 5) != 0));
        end
        idle(12);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule